// File: doc/BRIEF.md
# Serial Channel Command and Mode Register Front End

This block is the control side of a multi-channel asynchronous serial controller. A byte-wide register bus reaches each channel through a block of eight addresses. Command-register writes become receiver and transmitter enable levels and single-cycle reset strobes. A break request drives the line low. The three mode registers share one address and are selected by an internal pointer. Commands reposition the pointer, and every mode access advances it. A clock-select byte is latched per channel. A status byte is assembled from simple receive and transmit stubs, which stand in for the real serializer, FIFOs and baud generator.

The stubs accept received bytes from the `line_rx_*` inputs and hand transmit bytes to the `line_tx_*` outputs. Their only purpose is to give the status flags and the reset commands something real to act on.

Top module: `ser_chan_ctrl`

## Requirements
- R1: Channel c owns addresses c*8 to c*8+7, with the channel index in address bits 3 and up. The offsets are: 0 mode, 1 status (read) or clock select (write), 2 command (write), 3 receive holding (read) or transmit holding (write). An access to one channel never changes another channel.
- R2: Command bits 0/1 enable/disable the receiver, and bits 2/3 enable/disable the transmitter. The new level appears the cycle after the write. If enable and disable are set together, disable wins. Other bits of the same write are still honoured.
- R3: Command code bits 7:4 of 2, 3, 4 and 5 raise the one-cycle strobes `rx_reset_stb`, `tx_reset_stb`, `err_reset_stb` and `brkchg_reset_stb` in the cycle after the write. The strobes can be combined with the enable bits in the same write.
- R4: Reset leaves the mode pointer at mode register 1 (`mode_ptr` encoding 0 = MR0, 1 = MR1, 2 = MR2). Code 1 moves it to MR1 and code 0xB moves it to MR0, both in the cycle after the write. Every read or write of offset 0 targets the pointed register and then advances MR0→MR1→MR2. Once at MR2 it stays there.
- R5: MR1 bits 1:0 appear as `cfg_data_bits` (0..3 meaning 5..8 data bits). Parity uses MR1 bits 4:2: 0 is even, 1 is odd, 4 is none. So `cfg_parity_en` is the inverse of bit 4 and `cfg_parity_odd` is bit 2. MR2 bits 3:0 appear as `cfg_stop_code` (7 for one stop bit, 0xF for two). Mode reads return the pointed register.
- R6: MR0 bit 3 drives `cfg_fifo_ext`, bit 4 drives `cfg_tx_half`, and bits 2:0 drive `cfg_baud_ext`.
- R7: A write to offset 1 latches the clock-select byte. Its upper nibble is `cfg_rx_rate` and its lower nibble is `cfg_tx_rate`.
- R8: The status byte has these bits: 0 receive ready, 1 receive full, 2 transmit ready, 3 transmitter empty, 4 overrun, 5 parity error, 6 framing error, 7 received break. After reset it reads 0x0C.
- R9: While the receiver is enabled, a `line_rx_valid` byte enters a RX_DEPTH-deep queue. A byte that arrives when the queue is full is dropped and sets overrun. Reading offset 3 returns the oldest byte and removes it. With the receiver disabled, incoming bytes are ignored. The receive flag bits are 0 parity, 1 framing and 2 break; they set the sticky status bits when their byte is accepted.
- R10: Error-status reset clears only status bits 7:4 and leaves queued data alone. Receiver reset empties the queue (receive ready and full drop) and leaves the error bits alone. Both act one cycle after their strobe.
- R11: Code 6 drives `txd` low from the cycle after the write, and code 7 returns it high. A received byte flagged as break sets `brk_change`, which stays set until code 5 clears it.
- R12: A write to offset 3 fills the transmit holding register and clears transmit ready and transmitter empty. While the transmitter is enabled and idle, the held byte moves on with a one-cycle `line_tx_start` and `line_tx_data`, and transmit ready returns. `line_tx_done` makes the transmitter empty again. Transmitter reset drops both the held and the moving byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | CH_W+3 | Register address: channel in bits 3 and up, offset in 2:0 |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| line_rx_valid | input | NUM_CH | Receive stub: byte arrives |
| line_rx_data | input | NUM_CH*8 | Receive stub: byte value per channel |
| line_rx_flags | input | NUM_CH*3 | Receive stub: {break, framing, parity} per channel |
| line_tx_done | input | NUM_CH | Transmit stub: byte finished |
| line_tx_start | output | NUM_CH | Transmit stub: byte handed over |
| line_tx_data | output | NUM_CH*8 | Transmit stub: byte handed over |
| txd | output | NUM_CH | Line level, low during break |
| rx_enable | output | NUM_CH | Receiver enabled |
| tx_enable | output | NUM_CH | Transmitter enabled |
| rx_reset_stb | output | NUM_CH | Receiver reset strobe |
| tx_reset_stb | output | NUM_CH | Transmitter reset strobe |
| err_reset_stb | output | NUM_CH | Error status reset strobe |
| brkchg_reset_stb | output | NUM_CH | Break-change reset strobe |
| brk_change | output | NUM_CH | Break-change flag |
| mode_ptr | output | NUM_CH*2 | Mode pointer per channel |
| cfg_data_bits | output | NUM_CH*2 | Data length code |
| cfg_parity_en | output | NUM_CH | Parity enabled |
| cfg_parity_odd | output | NUM_CH | Odd parity |
| cfg_stop_code | output | NUM_CH*4 | Stop length code |
| cfg_fifo_ext | output | NUM_CH | Extended FIFO enabled |
| cfg_tx_half | output | NUM_CH | Half-full transmit-ready level |
| cfg_baud_ext | output | NUM_CH*3 | Extended baud table select |
| cfg_rx_rate | output | NUM_CH*4 | Receive rate code |
| cfg_tx_rate | output | NUM_CH*4 | Transmit rate code |

## Verification
Some properties are checked on every cycle by assertions:
- the mode pointer never takes its unused encoding, and it stays at MR2 without a pointer command;
- MR1 does not change on a mode write aimed elsewhere;
- disable beats enable, and a break command reaches the line state;
- the receive count stays within depth, and receiver reset empties the queue;
- transmit starts are isolated single-cycle pulses.

Other behaviour needs the directed scenarios:
- the field positions in every register, and the exact pointer sequence across mixed reads and writes;
- the overrun-on-full drop and the oldest-first read order;
- that status reset and receiver reset each leave the other's bits alone;
- isolation between channels.

// File: rtl/ser_ctrl_pkg.sv
// Shared definitions for the serial channel control front end.
// Assumes byte-wide registers and eight addresses per channel.
package ser_ctrl_pkg;
    localparam int REG_W = 8;

    // Register offsets within a channel block
    localparam logic [2:0] OFS_MODE = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_CMD  = 3'd2;
    localparam logic [2:0] OFS_HOLD = 3'd3;

    // Command codes carried in bits 7:4 of the command byte
    localparam logic [3:0] CC_PTR1   = 4'h1;
    localparam logic [3:0] CC_RXRST  = 4'h2;
    localparam logic [3:0] CC_TXRST  = 4'h3;
    localparam logic [3:0] CC_ERRRST = 4'h4;
    localparam logic [3:0] CC_BRKCLR = 4'h5;
    localparam logic [3:0] CC_BRKON  = 4'h6;
    localparam logic [3:0] CC_BRKOFF = 4'h7;
    localparam logic [3:0] CC_PTR0   = 4'hB;

    typedef enum logic [1:0] {
        MP_MR0 = 2'd0,
        MP_MR1 = 2'd1,
        MP_MR2 = 2'd2
    } mptr_e;

    typedef struct packed {
        logic rx_rst;
        logic tx_rst;
        logic err_rst;
        logic brkchg_rst;
    } cmd_pulse_t;
endpackage

// File: rtl/ser_cmd_decode.sv
// Command register decoder for one channel.
// Turns a command write into enable levels, one-cycle reset strobes, the
// break state, and combinational mode-pointer load requests.
// Assumes at most one bus access per cycle.
module ser_cmd_decode
    import ser_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [REG_W-1:0] wdata,
    output logic             rx_en,
    output logic             tx_en,
    output logic             brk_active,
    output cmd_pulse_t       pulses,
    output logic             ptr_to_mr0,
    output logic             ptr_to_mr1
);
    logic [3:0] code;
    assign code = wdata[7:4];

    // Pointer load requests act in the same edge as the command write
    assign ptr_to_mr0 = cmd_wr && (code == CC_PTR0);
    assign ptr_to_mr1 = cmd_wr && (code == CC_PTR1);

    // Enable levels, break state and single-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en      <= 1'b0;
            tx_en      <= 1'b0;
            brk_active <= 1'b0;
            pulses     <= '0;
        end else begin
            pulses <= '0;
            if (cmd_wr) begin
                if (wdata[1])      rx_en <= 1'b0;
                else if (wdata[0]) rx_en <= 1'b1;
                if (wdata[3])      tx_en <= 1'b0;
                else if (wdata[2]) tx_en <= 1'b1;
                case (code)
                    CC_RXRST:  pulses.rx_rst     <= 1'b1;
                    CC_TXRST:  pulses.tx_rst     <= 1'b1;
                    CC_ERRRST: pulses.err_rst    <= 1'b1;
                    CC_BRKCLR: pulses.brkchg_rst <= 1'b1;
                    CC_BRKON:  brk_active        <= 1'b1;
                    CC_BRKOFF: brk_active        <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    a_r2_rx_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[1]) |=> !rx_en);
    a_r2_tx_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[3]) |=> !tx_en);
    a_r11_break_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && code == CC_BRKON) |=> brk_active);
endmodule

// File: rtl/ser_mode_bank.sv
// Mode registers and clock-select latch for one channel.
// MR0..MR2 share one address; an internal pointer picks the target and
// advances after each access, saturating at MR2. Reset points at MR1.
module ser_mode_bank
    import ser_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic             mode_rd,
    input  logic             csel_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             ptr_to_mr0,
    input  logic             ptr_to_mr1,
    output mptr_e            ptr,
    output logic [REG_W-1:0] mr0,
    output logic [REG_W-1:0] mr1,
    output logic [REG_W-1:0] mr2,
    output logic [REG_W-1:0] csel,
    output logic [REG_W-1:0] mode_rdata
);
    // Pointer movement and pointed-register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= MP_MR1;
            mr0 <= '0;
            mr1 <= '0;
            mr2 <= '0;
        end else if (ptr_to_mr0) begin
            ptr <= MP_MR0;
        end else if (ptr_to_mr1) begin
            ptr <= MP_MR1;
        end else if (mode_wr || mode_rd) begin
            if (mode_wr) begin
                case (ptr)
                    MP_MR0:  mr0 <= wdata;
                    MP_MR1:  mr1 <= wdata;
                    default: mr2 <= wdata;
                endcase
            end
            case (ptr)
                MP_MR0:  ptr <= MP_MR1;
                default: ptr <= MP_MR2;
            endcase
        end
    end

    // Clock-select byte latch
    always_ff @(posedge clk) begin
        if (!rst_n)       csel <= '0;
        else if (csel_wr) csel <= wdata;
    end

    // Read view of the pointed mode register
    always_comb begin
        case (ptr)
            MP_MR0:  mode_rdata = mr0;
            MP_MR1:  mode_rdata = mr1;
            default: mode_rdata = mr2;
        endcase
    end

    a_r4_ptr_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ptr != 2'd3);
    a_r4_mr2_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == MP_MR2 && !ptr_to_mr0 && !ptr_to_mr1) |=> ptr == MP_MR2);
    a_r5_mr1_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && ptr != MP_MR1 && !ptr_to_mr0 && !ptr_to_mr1) |=> $stable(mr1));
endmodule

// File: rtl/ser_line_stub.sv
// Receive and transmit stand-ins for one channel.
// Holds a small receive queue with sticky error flags, and a transmit
// holding/shift pair. Assembles the channel status byte.
// Assumes the reset strobes arrive as single-cycle pulses.
module ser_line_stub
    import ser_ctrl_pkg::*;
#(
    parameter int RX_DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             tx_en,
    input  cmd_pulse_t       pulses,
    input  logic             rx_valid,
    input  logic [REG_W-1:0] rx_data,
    input  logic [2:0]       rx_flags,
    input  logic             hold_rd,
    input  logic             hold_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             tx_done,
    output logic [REG_W-1:0] status,
    output logic [REG_W-1:0] rx_head,
    output logic             tx_start,
    output logic [REG_W-1:0] tx_data,
    output logic             brk_change
);
    localparam int PTR_W = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
    localparam int CNT_W = $clog2(RX_DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(RX_DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(RX_DEPTH - 1);

    logic [REG_W-1:0] queue [RX_DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             ovr, pe, fe, brk;
    logic             hold_full, busy;
    logic [REG_W-1:0] hold_data;
    logic             is_full, pop, arrive, push, drop, move;

    assign is_full = (count == FULL_CNT);
    assign pop     = hold_rd && (count != '0) && !pulses.rx_rst;
    assign arrive  = rx_valid && rx_en && !pulses.rx_rst;
    assign push    = arrive && (!is_full || pop);
    assign drop    = arrive && is_full && !pop;
    assign move    = hold_full && !busy && tx_en;

    // Receive queue storage
    always_ff @(posedge clk) begin
        if (push) queue[wr_ptr] <= rx_data;
    end

    // Receive queue pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || pulses.rx_rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    // Sticky error flags and break-change flag; a new event beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ovr, pe, fe, brk, brk_change} <= '0;
        end else begin
            ovr        <= (ovr && !pulses.err_rst) || drop;
            pe         <= (pe  && !pulses.err_rst) || (push && rx_flags[0]);
            fe         <= (fe  && !pulses.err_rst) || (push && rx_flags[1]);
            brk        <= (brk && !pulses.err_rst) || (push && rx_flags[2]);
            brk_change <= (brk_change && !pulses.brkchg_rst) || (push && rx_flags[2]);
        end
    end

    // Transmit holding register and shifter-busy stand-in
    always_ff @(posedge clk) begin
        if (!rst_n || pulses.tx_rst) begin
            hold_full <= 1'b0;
            busy      <= 1'b0;
            tx_start  <= 1'b0;
            hold_data <= '0;
            tx_data   <= '0;
        end else begin
            tx_start <= 1'b0;
            if (tx_done) busy <= 1'b0;
            if (move) begin
                busy      <= 1'b1;
                tx_start  <= 1'b1;
                tx_data   <= hold_data;
                hold_full <= 1'b0;
            end
            if (hold_wr) begin
                hold_full <= 1'b1;
                hold_data <= wdata;
            end
        end
    end

    assign rx_head = queue[rd_ptr];
    assign status  = {brk, fe, pe, ovr, !hold_full && !busy, !hold_full,
                      is_full, count != '0};

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    a_r10_rx_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
        pulses.rx_rst |=> (count == '0));
    a_r12_start_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
    a_r12_start_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (busy || pulses.tx_rst));
endmodule

// File: rtl/ser_chan_ctrl.sv
// Multi-channel command/mode register front end.
// Decodes the byte bus into per-channel blocks of eight addresses (channel
// in address bits 3 and up) and instantiates decoder, mode bank and line
// stubs for each channel. Reads are combinational; side effects of reads
// (pointer advance, queue pop) take place at the clock edge.
module ser_chan_ctrl
    import ser_ctrl_pkg::*;
#(
    parameter int CH_W     = 1,
    parameter int RX_DEPTH = 3,
    localparam int NUM_CH  = 1 << CH_W,
    localparam int ADDR_W  = CH_W + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [NUM_CH-1:0]     line_rx_valid,
    input  logic [NUM_CH*8-1:0]   line_rx_data,
    input  logic [NUM_CH*3-1:0]   line_rx_flags,
    input  logic [NUM_CH-1:0]     line_tx_done,
    output logic [NUM_CH-1:0]     line_tx_start,
    output logic [NUM_CH*8-1:0]   line_tx_data,
    output logic [NUM_CH-1:0]     txd,
    output logic [NUM_CH-1:0]     rx_enable,
    output logic [NUM_CH-1:0]     tx_enable,
    output logic [NUM_CH-1:0]     rx_reset_stb,
    output logic [NUM_CH-1:0]     tx_reset_stb,
    output logic [NUM_CH-1:0]     err_reset_stb,
    output logic [NUM_CH-1:0]     brkchg_reset_stb,
    output logic [NUM_CH-1:0]     brk_change,
    output logic [NUM_CH*2-1:0]   mode_ptr,
    output logic [NUM_CH*2-1:0]   cfg_data_bits,
    output logic [NUM_CH-1:0]     cfg_parity_en,
    output logic [NUM_CH-1:0]     cfg_parity_odd,
    output logic [NUM_CH*4-1:0]   cfg_stop_code,
    output logic [NUM_CH-1:0]     cfg_fifo_ext,
    output logic [NUM_CH-1:0]     cfg_tx_half,
    output logic [NUM_CH*3-1:0]   cfg_baud_ext,
    output logic [NUM_CH*4-1:0]   cfg_rx_rate,
    output logic [NUM_CH*4-1:0]   cfg_tx_rate
);
    logic [CH_W-1:0]  ch_sel;
    logic [2:0]       ofs;
    logic [REG_W-1:0] stat_v  [NUM_CH];
    logic [REG_W-1:0] mode_v  [NUM_CH];
    logic [REG_W-1:0] head_v  [NUM_CH];

    assign ch_sel = bus_addr[ADDR_W-1:3];
    assign ofs    = bus_addr[2:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic             hit;
        logic             rx_en_c, tx_en_c, brk_c, to0, to1;
        cmd_pulse_t       pl;
        mptr_e            ptr_c;
        logic [REG_W-1:0] mr0_c, mr1_c, mr2_c, csel_c;

        assign hit = (ch_sel == CH_W'(c));

        ser_cmd_decode u_dec (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_wr     (bus_wr && hit && ofs == OFS_CMD),
            .wdata      (bus_wdata),
            .rx_en      (rx_en_c),
            .tx_en      (tx_en_c),
            .brk_active (brk_c),
            .pulses     (pl),
            .ptr_to_mr0 (to0),
            .ptr_to_mr1 (to1)
        );

        ser_mode_bank u_mode (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_wr    (bus_wr && hit && ofs == OFS_MODE),
            .mode_rd    (bus_rd && hit && ofs == OFS_MODE),
            .csel_wr    (bus_wr && hit && ofs == OFS_STAT),
            .wdata      (bus_wdata),
            .ptr_to_mr0 (to0),
            .ptr_to_mr1 (to1),
            .ptr        (ptr_c),
            .mr0        (mr0_c),
            .mr1        (mr1_c),
            .mr2        (mr2_c),
            .csel       (csel_c),
            .mode_rdata (mode_v[c])
        );

        ser_line_stub #(.RX_DEPTH(RX_DEPTH)) u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .rx_en      (rx_en_c),
            .tx_en      (tx_en_c),
            .pulses     (pl),
            .rx_valid   (line_rx_valid[c]),
            .rx_data    (line_rx_data[c*8 +: 8]),
            .rx_flags   (line_rx_flags[c*3 +: 3]),
            .hold_rd    (bus_rd && hit && ofs == OFS_HOLD),
            .hold_wr    (bus_wr && hit && ofs == OFS_HOLD),
            .wdata      (bus_wdata),
            .tx_done    (line_tx_done[c]),
            .status     (stat_v[c]),
            .rx_head    (head_v[c]),
            .tx_start   (line_tx_start[c]),
            .tx_data    (line_tx_data[c*8 +: 8]),
            .brk_change (brk_change[c])
        );

        assign txd[c]              = !brk_c;
        assign rx_enable[c]        = rx_en_c;
        assign tx_enable[c]        = tx_en_c;
        assign rx_reset_stb[c]     = pl.rx_rst;
        assign tx_reset_stb[c]     = pl.tx_rst;
        assign err_reset_stb[c]    = pl.err_rst;
        assign brkchg_reset_stb[c] = pl.brkchg_rst;
        assign mode_ptr[c*2 +: 2]  = ptr_c;
        assign cfg_data_bits[c*2 +: 2] = mr1_c[1:0];
        assign cfg_parity_en[c]    = !mr1_c[4];
        assign cfg_parity_odd[c]   = mr1_c[2];
        assign cfg_stop_code[c*4 +: 4] = mr2_c[3:0];
        assign cfg_fifo_ext[c]     = mr0_c[3];
        assign cfg_tx_half[c]      = mr0_c[4];
        assign cfg_baud_ext[c*3 +: 3]  = mr0_c[2:0];
        assign cfg_rx_rate[c*4 +: 4]   = csel_c[7:4];
        assign cfg_tx_rate[c*4 +: 4]   = csel_c[3:0];
    end

    // Read multiplexer over the selected channel and offset
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_sel == CH_W'(c)) begin
                case (ofs)
                    OFS_MODE: bus_rdata = mode_v[c];
                    OFS_STAT: bus_rdata = stat_v[c];
                    OFS_HOLD: bus_rdata = head_v[c];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_reset_stb[0], tx_reset_stb[0], err_reset_stb[0], brkchg_reset_stb[0]}));
endmodule

// File: tb/tb_ser_chan_ctrl.sv
// Directed bench for the channel command/mode front end.
module tb_ser_chan_ctrl;
    localparam int CH_W = 1;
    localparam int NUM_CH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [NUM_CH-1:0] line_rx_valid = '0;
    logic [NUM_CH*8-1:0] line_rx_data = '0;
    logic [NUM_CH*3-1:0] line_rx_flags = '0;
    logic [NUM_CH-1:0] line_tx_done = '0;
    logic [NUM_CH-1:0] line_tx_start, txd, rx_enable, tx_enable;
    logic [NUM_CH-1:0] rx_reset_stb, tx_reset_stb, err_reset_stb, brkchg_reset_stb;
    logic [NUM_CH-1:0] brk_change, cfg_parity_en, cfg_parity_odd, cfg_fifo_ext, cfg_tx_half;
    logic [NUM_CH*8-1:0] line_tx_data;
    logic [NUM_CH*2-1:0] mode_ptr, cfg_data_bits;
    logic [NUM_CH*4-1:0] cfg_stop_code, cfg_rx_rate, cfg_tx_rate;
    logic [NUM_CH*3-1:0] cfg_baud_ext;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    ser_chan_ctrl #(.CH_W(CH_W), .RX_DEPTH(3)) dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push(input int ch, input logic [7:0] d, input logic [2:0] f);
        @(negedge clk);
        line_rx_valid[ch] = 1'b1;
        line_rx_data[ch*8 +: 8] = d;
        line_rx_flags[ch*3 +: 3] = f;
        @(negedge clk);
        line_rx_valid = '0;
        line_rx_flags = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(4'h1, v);
        check("R8 reset status", v, 8'h0C);
        check("R4 reset pointer", mode_ptr, 4'b0101);
        check("R2 reset enables", {rx_enable, tx_enable}, 4'b0000);
        check("R11 reset txd", txd, 2'b11);
    endtask

    task automatic t_enables();
        wr(4'h2, 8'h05);
        check("R2 enable both", {rx_enable[0], tx_enable[0]}, 2'b11);
        wr(4'h2, 8'h03);
        check("R2 disable wins rx", rx_enable[0], 1'b0);
        check("R2 tx untouched", tx_enable[0], 1'b1);
        wr(4'h2, 8'h0C);
        check("R2 disable wins tx", tx_enable[0], 1'b0);
    endtask

    task automatic t_strobes();
        wr(4'h2, 8'h20);
        check("R3 rx reset strobe", rx_reset_stb, 2'b01);
        idle(1);
        check("R3 rx reset one cycle", rx_reset_stb, 2'b00);
        wr(4'h2, 8'h34);
        check("R3 tx reset strobe", tx_reset_stb, 2'b01);
        check("R3 combined enable", tx_enable[0], 1'b1);
        wr(4'h2, 8'h40);
        check("R3 error reset strobe", {err_reset_stb, tx_reset_stb}, 4'b0100);
        wr(4'h2, 8'h50);
        check("R3 break-change strobe", brkchg_reset_stb, 2'b01);
        wr(4'h2, 8'h08);
    endtask

    task automatic t_modes();
        logic [7:0] v;
        wr(4'h2, 8'h10);
        check("R4 pointer to MR1", mode_ptr[1:0], 2'd1);
        wr(4'h0, 8'h05);
        check("R4 advance to MR2", mode_ptr[1:0], 2'd2);
        check("R5 data bits", cfg_data_bits[1:0], 2'd1);
        check("R5 parity odd", {cfg_parity_en[0], cfg_parity_odd[0]}, 2'b11);
        wr(4'h0, 8'h0F);
        check("R5 two stop code", cfg_stop_code[3:0], 4'hF);
        wr(4'h0, 8'h07);
        check("R4 stays MR2", {mode_ptr[1:0], cfg_stop_code[3:0], cfg_data_bits[1:0]}, {2'd2, 4'h7, 2'd1});
        wr(4'h2, 8'h10);
        rd(4'h0, v);
        check("R5 read MR1", v, 8'h05);
        rd(4'h0, v);
        check("R5 read MR2", v, 8'h07);
        check("R4 read advances", mode_ptr[1:0], 2'd2);
        wr(4'h2, 8'h10);
        wr(4'h0, 8'h10);
        check("R5 parity none", cfg_parity_en[0], 1'b0);
        wr(4'h2, 8'hB0);
        check("R4 pointer to MR0", mode_ptr[1:0], 2'd0);
        wr(4'h0, 8'h1D);
        check("R6 fifo/half/baud", {cfg_fifo_ext[0], cfg_tx_half[0], cfg_baud_ext[2:0]}, {2'b11, 3'd5});
        check("R4 MR0 then MR1", mode_ptr, 4'b0101);
    endtask

    task automatic t_csel_channels();
        wr(4'h1, 8'hB6);
        check("R7 rate nibbles", {cfg_rx_rate[3:0], cfg_tx_rate[3:0]}, 8'hB6);
        wr(4'h9, 8'h3C);
        check("R1 ch1 rates", {cfg_rx_rate[7:4], cfg_tx_rate[7:4]}, 8'h3C);
        check("R1 ch0 rates kept", {cfg_rx_rate[3:0], cfg_tx_rate[3:0]}, 8'hB6);
        wr(4'hA, 8'h01);
        check("R1 ch1 command only", rx_enable, 2'b10);
        wr(4'hA, 8'h02);
    endtask

    task automatic t_receive();
        logic [7:0] v;
        wr(4'h2, 8'h01);
        push(0, 8'hA5, 3'b000);
        rd(4'h1, v);
        check("R9 receive ready", v, 8'h0D);
        push(0, 8'h5A, 3'b000);
        push(0, 8'h33, 3'b000);
        rd(4'h1, v);
        check("R9 full", v, 8'h0F);
        push(0, 8'hEE, 3'b000);
        rd(4'h1, v);
        check("R9 overrun on full", v, 8'h1F);
        rd(4'h3, v);
        check("R9 oldest first", v, 8'hA5);
        rd(4'h3, v);
        check("R9 second byte", v, 8'h5A);
        rd(4'hB, v);
        check("R1 ch1 hold empty", v, 8'h00);
        wr(4'h2, 8'h40);
        idle(1);
        rd(4'h1, v);
        check("R10 status reset keeps data", v, 8'h0D);
        push(0, 8'h11, 3'b011);
        rd(4'h1, v);
        check("R8 parity and framing bits", v, 8'h6D);
        push(0, 8'h22, 3'b100);
        rd(4'h1, v);
        check("R8 break bit", v, 8'hEF);
        check("R11 break change set", brk_change, 2'b01);
        wr(4'h2, 8'h20);
        idle(1);
        rd(4'h1, v);
        check("R10 rx reset keeps errors", v, 8'hEC);
        wr(4'h2, 8'h40);
        idle(1);
        rd(4'h1, v);
        check("R10 status reset clears errors", v, 8'h0C);
        wr(4'h2, 8'h50);
        idle(1);
        check("R11 break change cleared", brk_change, 2'b00);
        wr(4'h2, 8'h02);
        push(0, 8'h44, 3'b111);
        rd(4'h1, v);
        check("R9 disabled receiver ignores", v, 8'h0C);
        check("R9 disabled no break change", brk_change, 2'b00);
    endtask

    task automatic t_break();
        wr(4'h2, 8'h60);
        check("R11 break drives low", txd, 2'b10);
        wr(4'h2, 8'h70);
        check("R11 break released", txd, 2'b11);
    endtask

    task automatic t_transmit();
        logic [7:0] v;
        wr(4'h3, 8'h3C);
        rd(4'h1, v);
        check("R12 holding full", v[3:2], 2'b00);
        check("R12 no start while disabled", line_tx_start, 2'b00);
        wr(4'h2, 8'h04);
        check("R12 start not yet", line_tx_start, 2'b00);
        idle(1);
        check("R12 start pulse", {line_tx_start, line_tx_data[7:0]}, {2'b01, 8'h3C});
        rd(4'h1, v);
        check("R12 ready, not empty", v[3:2], 2'b01);
        check("R12 start one cycle", line_tx_start, 2'b00);
        @(negedge clk); line_tx_done[0] = 1'b1;
        @(negedge clk); line_tx_done[0] = 1'b0;
        rd(4'h1, v);
        check("R12 empty after done", v[3:2], 2'b11);
        wr(4'h2, 8'h08);
        wr(4'h3, 8'h77);
        wr(4'h2, 8'h30);
        idle(1);
        rd(4'h1, v);
        check("R12 tx reset drops byte", v[3:2], 2'b11);
    endtask

    initial begin
        #2_000_000;
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enables();
        t_strobes();
        t_modes();
        t_csel_channels();
        t_receive();
        t_break();
        t_transmit();
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule